// File: doc/BRIEF.md
# Two-Channel PCM Slot Port

This block is the digital side of a two-channel voice codec's PCM port. A bit clock and two frame syncs, one for each direction, arrive from outside. The block samples them with its own system clock and detects their edges. On the transmit side it shifts the two 8-bit channel codes out through open-drain pads. On the receive side it collects the incoming bits and presents both channel codes as parallel bytes, along with a single-cycle valid strobe.

A layout input chooses between two arrangements. In parallel layout each channel has its own transmit lane and its own receive pin, and both channels run with identical timing in an 8-bit slot. In serial layout the two channels share one 16-bit slot, with channel 1 first. That slot goes out on transmit lane 1 and comes in on receive pin 2, while transmit lane 2 stays released and receive pin 1 is not used. A power-up input releases every output and halts both directions when it is low. Companding, clock recovery and the analog path are outside this block.

Top module: `pcm_duo_port`

## Requirements
- R1: A transmit slot starts at the first bit-clock rising edge at which `fs_tx` is sampled high after being sampled low at the previous rising edge. The MSB is driven from that edge onwards, and each later bit is driven from the following rising edge, MSB first.
- R2: Receive bits are sampled on bit-clock falling edges. The first falling edge at which `fs_rx` is seen high after being low captures the MSB.
- R3: In parallel layout (`par_mode`=1), `tx_code1` goes out on lane 1 and `tx_code2` on lane 2 in the same 8 bit periods. `rx_pin1` fills `rx_code1` and `rx_pin2` fills `rx_code2`.
- R4: In serial layout (`par_mode`=0), 16 bits go out on lane 1, `tx_code1` first and then `tx_code2`. `tx_oe2` stays 0 for the whole slot.
- R5: In serial layout, 16 bits are taken from `rx_pin2`. The first 8 form `rx_code1` and the last 8 form `rx_code2`. `rx_pin1` has no effect.
- R6: Open-drain modelling: `tx_oeN` is 1 exactly while the lane drives a 0 bit inside its slot. It is 0 for 1 bits and from the bit-clock rising edge that follows the last bit until the next slot starts.
- R7: While `pwr_up` is 0, both `tx_oe` outputs are 0 from the next clock onwards, any slot in progress is abandoned, and `rx_valid` never rises.
- R8: Once the last bit of a receive slot has been sampled, `rx_valid` pulses for one clock with both codes updated. The codes then hold until the next complete slot.
- R9: A new frame sync in the middle of a slot restarts that direction's bit count. Partly received bits are discarded, and transmission restarts with the MSB of the codes present at that moment.
- R10: After reset, `tx_oe1`, `tx_oe2` and `rx_valid` are 0.
- R11: Receive bits that arrive after a slot has ended produce no `rx_valid` until a new frame sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up | input | 1 | 1 = operating, 0 = powered down (outputs released) |
| par_mode | input | 1 | 1 = parallel layout, 0 = serial layout |
| bclk | input | 1 | External PCM bit clock |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| tx_code1 | input | CODE_W | Channel 1 code to transmit |
| tx_code2 | input | CODE_W | Channel 2 code to transmit |
| rx_pin1 | input | 1 | Receive data pin 1 |
| rx_pin2 | input | 1 | Receive data pin 2 (shared stream in serial layout) |
| tx_oe1 | output | 1 | Lane 1 pull-down enable (pad low when 1, released when 0) |
| tx_oe2 | output | 1 | Lane 2 pull-down enable |
| rx_code1 | output | CODE_W | Last received channel 1 code |
| rx_code2 | output | CODE_W | Last received channel 2 code |
| rx_valid | output | 1 | One-cycle strobe marking new receive codes |

## Verification
The bench builds the block with its default parameters: an 8-bit code and a two-stage input synchronizer. This gives a fixed latency of three system clocks from a pin change to a registered reaction. The bench holds each bit-clock half period for eight system clocks, so every output can be sampled once it has settled inside the same half period. Frames run in both layouts, with codes made of all ones, all zeros and alternating bits. Some frames are cut short by a fresh sync, and one frame runs with power removed. Junk on the unused receive pin and on trailing bits exposes any lane mix-up or any slot that runs past its end.

// File: rtl/pcm_duo_pkg.sv
package pcm_duo_pkg;

   typedef enum logic {
      LAYOUT_SERIAL   = 1'b0,
      LAYOUT_PARALLEL = 1'b1
   } layout_e;

   typedef struct packed {
      logic bclk;
      logic fs_tx;
      logic fs_rx;
      logic din1;
      logic din2;
   } pcm_pins_t;

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
   parameter int W      = 5,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pcm_tx_slot.sv
module pcm_tx_slot
   import pcm_duo_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  layout_e           layout,
   input  logic              bit_rise,
   input  logic              fs_lvl,
   input  logic [CODE_W-1:0] code1,
   input  logic [CODE_W-1:0] code2,
   output logic              oe1,
   output logic              oe2,
   output layout_e           lay_q
);
   localparam int FRAME_W = 2 * CODE_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   logic              fs_seen;
   logic              busy;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  len;
   logic [FRAME_W-1:0] sh_a;
   logic [CODE_W-1:0] sh_b;
   logic              start;

   assign start = bit_rise & fs_lvl & ~fs_seen;
   assign len   = (lay_q == LAYOUT_PARALLEL) ? CNT_W'(CODE_W) : CNT_W'(FRAME_W);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_seen <= 1'b0;
         busy    <= 1'b0;
         cnt     <= '0;
         sh_a    <= '0;
         sh_b    <= '0;
         oe1     <= 1'b0;
         oe2     <= 1'b0;
         lay_q   <= LAYOUT_SERIAL;
      end else begin
         if (bit_rise) fs_seen <= fs_lvl;
         if (!en) begin
            busy <= 1'b0;
            cnt  <= '0;
            oe1  <= 1'b0;
            oe2  <= 1'b0;
         end else if (start) begin
            lay_q <= layout;
            busy  <= 1'b1;
            cnt   <= CNT_W'(1);
            sh_a  <= {code1, code2} << 1;
            sh_b  <= code2 << 1;
            oe1   <= ~code1[CODE_W-1];
            oe2   <= (layout == LAYOUT_PARALLEL) & ~code2[CODE_W-1];
         end else if (bit_rise && busy) begin
            if (cnt == len) begin
               busy <= 1'b0;
               oe1  <= 1'b0;
               oe2  <= 1'b0;
            end else begin
               oe1  <= ~sh_a[FRAME_W-1];
               oe2  <= (lay_q == LAYOUT_PARALLEL) & ~sh_b[CODE_W-1];
               sh_a <= sh_a << 1;
               sh_b <= sh_b << 1;
               cnt  <= cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_rx_slot.sv
module pcm_rx_slot
   import pcm_duo_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  layout_e           layout,
   input  logic              bit_fall,
   input  logic              fs_lvl,
   input  logic              din1,
   input  logic              din2,
   output logic [CODE_W-1:0] code1,
   output logic [CODE_W-1:0] code2,
   output logic              valid
);
   localparam int FRAME_W = 2 * CODE_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   layout_e            lay_q;
   layout_e            cur_lay;
   logic               fs_seen;
   logic               busy;
   logic               start;
   logic               lane_a;
   logic [CNT_W-1:0]   cnt;
   logic [CNT_W-1:0]   nxt_cnt;
   logic [CNT_W-1:0]   cur_len;
   logic [FRAME_W-2:0] sh_a;
   logic [CODE_W-2:0]  sh_b;
   logic [FRAME_W-1:0] nxt_a;
   logic [CODE_W-1:0]  nxt_b;

   assign start = bit_fall & fs_lvl & ~fs_seen;

   always_comb begin
      cur_lay = start ? layout : lay_q;
      lane_a  = (cur_lay == LAYOUT_PARALLEL) ? din1 : din2;
      cur_len = (cur_lay == LAYOUT_PARALLEL) ? CNT_W'(CODE_W) : CNT_W'(FRAME_W);
      if (start) begin
         nxt_a   = {{(FRAME_W-1){1'b0}}, lane_a};
         nxt_b   = {{(CODE_W-1){1'b0}}, din2};
         nxt_cnt = CNT_W'(1);
      end else begin
         nxt_a   = {sh_a, lane_a};
         nxt_b   = {sh_b, din2};
         nxt_cnt = cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lay_q   <= LAYOUT_SERIAL;
         fs_seen <= 1'b0;
         busy    <= 1'b0;
         cnt     <= '0;
         sh_a    <= '0;
         sh_b    <= '0;
         code1   <= '0;
         code2   <= '0;
         valid   <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (bit_fall) fs_seen <= fs_lvl;
         if (!en) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else if (bit_fall && (start || busy)) begin
            if (start) lay_q <= layout;
            sh_a <= nxt_a[FRAME_W-2:0];
            sh_b <= nxt_b[CODE_W-2:0];
            cnt  <= nxt_cnt;
            if (nxt_cnt == cur_len) begin
               busy  <= 1'b0;
               valid <= 1'b1;
               if (cur_lay == LAYOUT_PARALLEL) begin
                  code1 <= nxt_a[CODE_W-1:0];
                  code2 <= nxt_b;
               end else begin
                  code1 <= nxt_a[FRAME_W-1:CODE_W];
                  code2 <= nxt_a[CODE_W-1:0];
               end
            end else begin
               busy <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pcm_duo_port.sv
module pcm_duo_port
   import pcm_duo_pkg::*;
#(
   parameter int CODE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_up,
   input  logic              par_mode,
   input  logic              bclk,
   input  logic              fs_tx,
   input  logic              fs_rx,
   input  logic [CODE_W-1:0] tx_code1,
   input  logic [CODE_W-1:0] tx_code2,
   input  logic              rx_pin1,
   input  logic              rx_pin2,
   output logic              tx_oe1,
   output logic              tx_oe2,
   output logic [CODE_W-1:0] rx_code1,
   output logic [CODE_W-1:0] rx_code2,
   output logic              rx_valid
);
   localparam int PIN_W = $bits(pcm_pins_t);

   generate
      if (CODE_W < 2 || SYNC_STAGES < 1) begin : g_bad_params
         $error("pcm_duo_port: CODE_W must be >= 2 and SYNC_STAGES >= 1");
      end
   endgenerate

   pcm_pins_t pin_raw;
   pcm_pins_t pin_q;
   logic      bclk_d;
   logic      bit_rise;
   logic      bit_fall;
   layout_e   lay_in;
   layout_e   tx_lay;

   assign pin_raw = '{bclk: bclk, fs_tx: fs_tx, fs_rx: fs_rx, din1: rx_pin1, din2: rx_pin2};
   assign lay_in  = layout_e'(par_mode);

   pcm_in_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_raw),
      .q     (pin_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_d <= 1'b0;
      else        bclk_d <= pin_q.bclk;
   end

   assign bit_rise = pin_q.bclk & ~bclk_d;
   assign bit_fall = ~pin_q.bclk & bclk_d;

   pcm_tx_slot #(.CODE_W(CODE_W)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pwr_up),
      .layout   (lay_in),
      .bit_rise (bit_rise),
      .fs_lvl   (pin_q.fs_tx),
      .code1    (tx_code1),
      .code2    (tx_code2),
      .oe1      (tx_oe1),
      .oe2      (tx_oe2),
      .lay_q    (tx_lay)
   );

   pcm_rx_slot #(.CODE_W(CODE_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (pwr_up),
      .layout   (lay_in),
      .bit_fall (bit_fall),
      .fs_lvl   (pin_q.fs_rx),
      .din1     (pin_q.din1),
      .din2     (pin_q.din2),
      .code1    (rx_code1),
      .code2    (rx_code2),
      .valid    (rx_valid)
   );
endmodule

// File: rtl/pcm_duo_port_chk.sv
module pcm_duo_port_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_up,
   input logic bit_rise,
   input logic bit_fall,
   input logic tx_lay,
   input logic tx_oe1,
   input logic tx_oe2,
   input logic rx_valid
);
   p_oe_moves_on_rise_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_oe1 != $past(tx_oe1)) |-> ($past(bit_rise) || !$past(pwr_up)));

   p_valid_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(bit_fall));

   p_serial_lane2_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_lay == 1'b0) |-> !tx_oe2);

   p_power_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_up |=> (!tx_oe1 && !tx_oe2 && !rx_valid));

   p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
endmodule

bind pcm_duo_port pcm_duo_port_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_up   (pwr_up),
   .bit_rise (bit_rise),
   .bit_fall (bit_fall),
   .tx_lay   (tx_lay),
   .tx_oe1   (tx_oe1),
   .tx_oe2   (tx_oe2),
   .rx_valid (rx_valid)
);

// File: tb/pcm_duo_port_test.sv
module pcm_duo_port_test;
   logic       clk = 1'b0;
   logic       rst_n;
   logic       pwr_up;
   logic       par_mode;
   logic       bclk;
   logic       fs_tx;
   logic       fs_rx;
   logic [7:0] tx_code1;
   logic [7:0] tx_code2;
   logic       rx_pin1;
   logic       rx_pin2;
   logic       tx_oe1;
   logic       tx_oe2;
   logic [7:0] rx_code1;
   logic [7:0] rx_code2;
   logic       rx_valid;

   int n_checks = 0;
   int n_fail   = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   pcm_duo_port uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwr_up   (pwr_up),
      .par_mode (par_mode),
      .bclk     (bclk),
      .fs_tx    (fs_tx),
      .fs_rx    (fs_rx),
      .tx_code1 (tx_code1),
      .tx_code2 (tx_code2),
      .rx_pin1  (rx_pin1),
      .rx_pin2  (rx_pin2),
      .tx_oe1   (tx_oe1),
      .tx_oe2   (tx_oe2),
      .rx_code1 (rx_code1),
      .rx_code2 (rx_code2),
      .rx_valid (rx_valid)
   );

   task automatic check(input string tag, input string what,
                        input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Scoreboard monitor: every receive strobe must match the oldest expected pair.
   always @(negedge clk) begin
      if (rst_n && rx_valid) begin
         if (exp_q.size() == 0) begin
            check("R11", "unexpected rx_valid", {rx_code1, rx_code2}, 16'hxxxx);
         end else begin
            check(tag_q.pop_front(), "received codes", {rx_code1, rx_code2}, exp_q.pop_front());
         end
      end
   end

   // Driver: one frame with both syncs tied, each bit-clock half period 8 clocks.
   task automatic run_frame(input bit par, input logic [7:0] t1, input logic [7:0] t2,
                            input logic [7:0] r1, input logic [7:0] r2,
                            input int run_bits, input int idle_bits, input bit live,
                            input string tx_tag, input string rx_tag);
      int n;
      logic [15:0] tx_s;
      logic [15:0] rx_s;
      n    = par ? 8 : 16;
      tx_s = {t1, t2};
      rx_s = {r1, r2};
      @(negedge clk);
      par_mode = par;
      tx_code1 = t1;
      tx_code2 = t2;
      if (live && run_bits >= n) begin
         exp_q.push_back(par ? {r1, r2} : rx_s);
         tag_q.push_back(rx_tag);
      end
      for (int k = 0; k < run_bits + idle_bits; k++) begin
         logic e1;
         logic e2;
         @(negedge clk);
         bclk  = 1'b1;
         fs_tx = (k == 0);
         fs_rx = (k == 0);
         if (k >= n) begin
            rx_pin1 = k[0];
            rx_pin2 = ~k[0];
         end else if (par) begin
            rx_pin1 = r1[7-k];
            rx_pin2 = r2[7-k];
         end else begin
            rx_pin2 = rx_s[15-k];
            rx_pin1 = ~rx_s[15-k];
         end
         repeat (8) @(negedge clk);
         if (!live || k >= n) begin
            e1 = 1'b0;
            e2 = 1'b0;
         end else if (par) begin
            e1 = ~t1[7-k];
            e2 = ~t2[7-k];
         end else begin
            e1 = ~tx_s[15-k];
            e2 = 1'b0;
         end
         check((k >= n && live) ? "R6" : tx_tag, $sformatf("tx lanes bit %0d", k),
               {14'd0, tx_oe1, tx_oe2}, {14'd0, e1, e2});
         bclk = 1'b0;
         repeat (7) @(negedge clk);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pwr_up = 1'b1; par_mode = 1'b1; bclk = 1'b0;
      fs_tx = 1'b0; fs_rx = 1'b0; tx_code1 = '0; tx_code2 = '0;
      rx_pin1 = 1'b0; rx_pin2 = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R10", "reset outputs", {13'd0, tx_oe1, tx_oe2, rx_valid}, 16'd0);

      // Parallel layout (R3), mixed and extreme codes; trailing bits R6/R11.
      run_frame(1'b1, 8'hA5, 8'h3C, 8'h96, 8'h0F, 8, 2, 1'b1, "R3", "R2");
      check("R8", "codes hold after slot", {rx_code1, rx_code2}, 16'h960F);
      run_frame(1'b1, 8'h00, 8'hFF, 8'hFF, 8'h00, 8, 2, 1'b1, "R6", "R3");

      // Serial layout: lane 1 carries both, lane 2 idle, rx_pin1 gets junk (R4, R5).
      run_frame(1'b0, 8'hC3, 8'h5A, 8'h81, 8'h7E, 16, 2, 1'b1, "R4", "R5");
      run_frame(1'b0, 8'h0F, 8'hF0, 8'h12, 8'h34, 16, 2, 1'b1, "R1", "R5");

      // Sync arriving mid-slot restarts the count (R9).
      run_frame(1'b1, 8'h00, 8'h00, 8'hFF, 8'hFF, 3, 0, 1'b1, "R9", "R9");
      run_frame(1'b1, 8'h69, 8'h96, 8'h3C, 8'hC3, 8, 2, 1'b1, "R9", "R9");
      run_frame(1'b0, 8'h00, 8'h00, 8'hAA, 8'hAA, 10, 0, 1'b1, "R9", "R9");
      run_frame(1'b0, 8'h55, 8'hE1, 8'h5B, 8'h2D, 16, 2, 1'b1, "R9", "R9");

      // Power removed: lanes stay released, no strobe (R7); then recovery.
      pwr_up = 1'b0;
      run_frame(1'b1, 8'h00, 8'h00, 8'h11, 8'h22, 8, 2, 1'b0, "R7", "R7");
      check("R7", "codes untouched while down", {rx_code1, rx_code2}, 16'h5B2D);
      pwr_up = 1'b1;
      run_frame(1'b1, 8'h00, 8'h00, 8'h11, 8'h22, 8, 2, 1'b1, "R7", "R8");

      repeat (20) @(negedge clk);
      check("R8", "pending strobes", 16'(exp_q.size()), 16'd0);
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule